// File: doc/BRIEF.md
# Window Watchdog with Filtered Trigger

This block supervises a microcontroller through one trigger input and holds an active-low reset output. The microcontroller must signal on the trigger pin once per period, and only inside an allowed time slot. A signal that arrives too early, or that never arrives, produces a reset pulse. The trigger pin is synchronised with two flops and then sampled once per `tick`, an enable pulse from the surrounding chip that sets the sample period. A trigger counts only when two HIGH samples are followed by two LOW samples, so short glitches are rejected. Every window length is a whole number of ticks.

The state machine has six states. `WS_OFF`: the watchdog is disabled and the reset output is released. `WS_IGNORE`: a settling window in which triggers are ignored. `WS_FIRST_OPEN`: an extended open window, `LONG_MUL` times the normal open length, that lets the microcontroller resynchronise. `WS_CLOSED`: a trigger here is a pretrigger fault. `WS_OPEN`: a trigger is expected here. `WS_RESET`: the reset output is held low for a fixed pulse length. The transitions are:
- `WS_IGNORE -> WS_FIRST_OPEN` when the ignore window expires.
- `WS_FIRST_OPEN` or `WS_OPEN` `-> WS_CLOSED` on a valid trigger.
- `WS_FIRST_OPEN` or `WS_OPEN` `-> WS_RESET` when the window times out.
- `WS_CLOSED -> WS_OPEN` when the closed window expires.
- `WS_CLOSED -> WS_RESET` on a pretrigger.
- `WS_RESET -> WS_IGNORE` when the pulse ends.
- Any state `-> WS_OFF` when the enable is lost.
- `WS_IGNORE -> WS_OFF` when the mode input selects off.
- `WS_OFF -> WS_IGNORE` when the enable is present and the mode is not off.

The enable comes from two digital flags supplied by an external load-current comparator, with hysteresis between them. A two-bit mode input selects fast timing or slow timing, or turns the watchdog off.

Top module: `win_watchdog`

## Requirements
- R1: After `rst_n` is released, the block is enabled, in `WS_IGNORE` with fast timing, and `rst_out_n` is 1.
- R2: The trigger pin is synchronised with two flops and then sampled on each `tick`. A trigger event is decoded only when the four newest samples, oldest first, read 1,1,0,0. Any other sequence, such as alternating samples or a single HIGH sample, decodes no event.
- R3: `WS_IGNORE` lasts `IGN_T` ticks. A trigger decoded during this window has no effect. When the window expires, the state moves to `WS_FIRST_OPEN`.
- R4: `WS_FIRST_OPEN` lasts at most `OPEN_T*LONG_MUL` ticks. A trigger ends it at once and enters `WS_CLOSED`. If it times out, the state moves to `WS_RESET`.
- R5: `WS_CLOSED` lasts `CLOSED_T` ticks and then enters `WS_OPEN`. A trigger decoded inside it enters `WS_RESET` on the following clock.
- R6: `WS_OPEN` lasts at most `OPEN_T` ticks. A trigger enters `WS_CLOSED`. A timeout enters `WS_RESET`.
- R7: The decision is taken when the fourth sample of the pattern is taken. If the first three samples fall inside `WS_CLOSED` and the fourth lands on the tick that opens `WS_OPEN`, the trigger is valid and no reset results.
- R8: `rst_out_n` is 0 exactly while in `WS_RESET`, which lasts `RST_T` ticks and then returns to `WS_IGNORE`, followed by the long first open window.
- R9: `cur_hi`=1 enables the block and `cur_lo`=1 disables it. If both flags are 1, `cur_hi` wins. If both are 0, the previous enable state is held. While the block is disabled, `rst_out_n` stays 1. Re-enabling restarts the sequence at `WS_IGNORE`.
- R10: `mode` is decoded as follows: 2'b00 selects fast timing, 2'b01 selects slow timing, in which every window and the reset pulse are `SLOW_MUL` times longer, and 2'b1x selects off. The mode is taken only in `WS_IGNORE` or `WS_OFF`. A change made in any other state has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| tick | input | 1 | One-cycle sample-period enable |
| trig_in | input | 1 | Trigger from the microcontroller, asynchronous |
| cur_lo | input | 1 | Load-current-low flag, disables the watchdog |
| cur_hi | input | 1 | Load-current-high flag, enables the watchdog |
| mode | input | 2 | Timing select: 00 fast, 01 slow, 1x off |
| rst_out_n | output | 1 | Active-low reset to the microcontroller |

## Verification
The hardest situations to reach are the two that sit on the boundary of the closed window. One is a trigger pattern whose last LOW sample lands exactly on the tick that opens `WS_OPEN`. The other is a pattern that completes one tick earlier, inside `WS_CLOSED`. The bench counts ticks from a known entry into `WS_IGNORE` and places the first trigger at a fixed tick. It then starts the next pattern directly after that trigger, so that its last sample falls on the first tick of `WS_OPEN`. A table of six-sample patterns, driven into the closed window after a controlled restart through the enable flags, shows which sequences are decoded: a decoded pattern shows up as a pretrigger reset.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    typedef enum logic [2:0] {
        WS_OFF        = 3'd0,
        WS_IGNORE     = 3'd1,
        WS_FIRST_OPEN = 3'd2,
        WS_CLOSED     = 3'd3,
        WS_OPEN       = 3'd4,
        WS_RESET      = 3'd5
    } wwd_state_e;

    localparam logic [1:0] MODE_FAST = 2'b00;
    localparam logic [1:0] MODE_SLOW = 2'b01;

endpackage

// File: rtl/wwd_trig_filter.sv
module wwd_trig_filter #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PAT_LEN     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic trig_in,
    output logic trg_ev
);
    localparam int unsigned HALF = PAT_LEN / 2;
    localparam logic [PAT_LEN-1:0] PATTERN = {{HALF{1'b1}}, {HALF{1'b0}}};

    logic [SYNC_STAGES-1:0] sync_q;
    logic [PAT_LEN-1:0]     smp_q;
    logic [PAT_LEN-1:0]     smp_nxt;

    assign smp_nxt = {smp_q[PAT_LEN-2:0], sync_q[SYNC_STAGES-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            smp_q  <= '0;
            trg_ev <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], trig_in};
            trg_ev <= 1'b0;
            if (tick) begin
                smp_q  <= smp_nxt;
                trg_ev <= (smp_nxt == PATTERN);
            end
        end
    end

endmodule

// File: rtl/wwd_enable_hyst.sv
module wwd_enable_hyst (
    input  logic clk,
    input  logic rst_n,
    input  logic cur_lo,
    input  logic cur_hi,
    output logic en_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      en_q <= 1'b1;
        else if (cur_hi) en_q <= 1'b1;
        else if (cur_lo) en_q <= 1'b0;
    end
endmodule

// File: rtl/wwd_fsm.sv
module wwd_fsm
    import wwd_pkg::*;
#(
    parameter int unsigned IGN_T    = 8,
    parameter int unsigned OPEN_T   = 8,
    parameter int unsigned CLOSED_T = 6,
    parameter int unsigned RST_T    = 3,
    parameter int unsigned LONG_MUL = 4,
    parameter int unsigned SLOW_MUL = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       trg_ev,
    input  logic       en_q,
    input  logic [1:0] mode,
    output wwd_state_e st,
    output logic       rst_out_n
);
    localparam int unsigned LONG_T = OPEN_T * LONG_MUL;
    localparam int unsigned MAX_A  = (IGN_T > LONG_T) ? IGN_T : LONG_T;
    localparam int unsigned MAX_B  = (CLOSED_T > RST_T) ? CLOSED_T : RST_T;
    localparam int unsigned MAX_F  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W  = $clog2(MAX_F * SLOW_MUL + 1);

    wwd_state_e       st_nxt;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;
    logic             slow_q;
    logic             expire;
    logic             mode_off;

    assign mode_off = mode[1];

    always_comb begin
        unique case (st)
            WS_IGNORE:     lim = slow_q ? CNT_W'(IGN_T * SLOW_MUL)    : CNT_W'(IGN_T);
            WS_FIRST_OPEN: lim = slow_q ? CNT_W'(LONG_T * SLOW_MUL)   : CNT_W'(LONG_T);
            WS_CLOSED:     lim = slow_q ? CNT_W'(CLOSED_T * SLOW_MUL) : CNT_W'(CLOSED_T);
            WS_OPEN:       lim = slow_q ? CNT_W'(OPEN_T * SLOW_MUL)   : CNT_W'(OPEN_T);
            WS_RESET:      lim = slow_q ? CNT_W'(RST_T * SLOW_MUL)    : CNT_W'(RST_T);
            default:       lim = '1;
        endcase
    end

    assign expire = tick && (cnt == lim - CNT_W'(1));

    always_comb begin
        st_nxt = st;
        if (!en_q) begin
            st_nxt = WS_OFF;
        end else begin
            unique case (st)
                WS_OFF:        if (!mode_off) st_nxt = WS_IGNORE;
                WS_IGNORE:     if (mode_off)  st_nxt = WS_OFF;
                               else if (expire) st_nxt = WS_FIRST_OPEN;
                WS_FIRST_OPEN,
                WS_OPEN:       if (trg_ev)    st_nxt = WS_CLOSED;
                               else if (expire) st_nxt = WS_RESET;
                WS_CLOSED:     if (trg_ev)    st_nxt = WS_RESET;
                               else if (expire) st_nxt = WS_OPEN;
                WS_RESET:      if (expire)    st_nxt = WS_IGNORE;
                default:       st_nxt = WS_IGNORE;
            endcase
        end
    end

    // state register, window counter and mode latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= WS_IGNORE;
            cnt    <= '0;
            slow_q <= 1'b0;
        end else begin
            st <= st_nxt;
            if (st_nxt != st || st == WS_OFF) cnt <= '0;
            else if (tick)                    cnt <= cnt + CNT_W'(1);
            if (st == WS_IGNORE || st == WS_OFF)
                slow_q <= (mode == MODE_SLOW);
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_out_n <= 1'b1;
        else        rst_out_n <= (st_nxt != WS_RESET);
    end

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wwd_pkg::*;
#(
    parameter int unsigned IGN_T       = 8,
    parameter int unsigned OPEN_T      = 8,
    parameter int unsigned CLOSED_T    = 6,
    parameter int unsigned RST_T       = 3,
    parameter int unsigned LONG_MUL    = 4,
    parameter int unsigned SLOW_MUL    = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PAT_LEN     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       trig_in,
    input  logic       cur_lo,
    input  logic       cur_hi,
    input  logic [1:0] mode,
    output logic       rst_out_n
);
    logic       trg_ev;
    logic       en_q;
    wwd_state_e st;

    wwd_trig_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .PAT_LEN    (PAT_LEN)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .trig_in(trig_in),
        .trg_ev (trg_ev)
    );

    wwd_enable_hyst u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .cur_lo(cur_lo),
        .cur_hi(cur_hi),
        .en_q  (en_q)
    );

    wwd_fsm #(
        .IGN_T   (IGN_T),
        .OPEN_T  (OPEN_T),
        .CLOSED_T(CLOSED_T),
        .RST_T   (RST_T),
        .LONG_MUL(LONG_MUL),
        .SLOW_MUL(SLOW_MUL)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .trg_ev   (trg_ev),
        .en_q     (en_q),
        .mode     (mode),
        .st       (st),
        .rst_out_n(rst_out_n)
    );

endmodule

// File: rtl/wwd_checker.sv
module wwd_checker
    import wwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trg_ev,
    input  logic       en_q,
    input  wwd_state_e st,
    input  logic       rst_out_n
);
    // R2
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trg_ev |=> !trg_ev);

    // R5
    pretrig_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WS_CLOSED && trg_ev && en_q) |=> !rst_out_n);

    // R6
    open_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == WS_OPEN || st == WS_FIRST_OPEN) && trg_ev && en_q)
        |=> (rst_out_n && st == WS_CLOSED));

    // R9
    off_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && $past(!en_q)) |-> rst_out_n);

    // R8
    reset_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> (st == WS_IGNORE || st == WS_OFF));

endmodule

bind win_watchdog wwd_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .trg_ev   (trg_ev),
    .en_q     (en_q),
    .st       (st),
    .rst_out_n(rst_out_n)
);

// File: tb/win_watchdog_bench.sv
module win_watchdog_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trig_in = 1'b0;
    logic       cur_lo = 1'b0;
    logic       cur_hi = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       rst_out_n;
    logic [1:0] div = 2'd0;
    logic       tick;
    int         total = 0;
    int         bad = 0;

    // six samples driven into the closed window, then 1 = pretrigger expected
    localparam logic [6:0] VEC_TAB [8] = '{
        7'b110000_1, 7'b011000_1, 7'b110011_1, 7'b101010_0,
        7'b100100_0, 7'b010100_0, 7'b111100_0, 7'b001100_0
    };

    always #10 clk = ~clk;

    always @(negedge clk) div <= div + 2'd1;
    assign tick = (div == 2'd3);

    win_watchdog u_win_watchdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .trig_in  (trig_in),
        .cur_lo   (cur_lo),
        .cur_hi   (cur_hi),
        .mode     (mode),
        .rst_out_n(rst_out_n)
    );

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!tick);
        end
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: rst_out_n=%0b expected %0b", tag, act, exp);
        end
    endtask

    // HIGH for two samples, LOW for two samples: decoded on the 4th tick
    task automatic pulse();
        trig_in = 1'b1;
        wait_ticks(2);
        trig_in = 1'b0;
        wait_ticks(2);
    endtask

    // controlled restart via the current flags; returns one tick into WS_IGNORE
    task automatic restart();
        trig_in = 1'b0;
        cur_lo  = 1'b1;
        wait_ticks(1);
        cur_lo  = 1'b0;
        cur_hi  = 1'b1;
        wait_ticks(1);
        cur_hi  = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset state", rst_out_n, 1'b1);

        // power-up: trigger in ignore window, then long first open window times out
        wait_ticks(1);
        pulse();                        // decoded at t5, inside ignore (R3)
        wait_ticks(34);
        chk("R3 R4 long open before timeout t39", rst_out_n, 1'b1);
        wait_ticks(1);
        chk("R4 long open timeout t40", rst_out_n, 1'b0);
        wait_ticks(2);
        chk("R8 reset pulse still low", rst_out_n, 1'b0);
        wait_ticks(1);
        chk("R8 reset pulse ends", rst_out_n, 1'b1);

        // normal operation, late-start trigger, open timeout (origin t0 = ignore entry)
        wait_ticks(10);
        pulse();                        // t14 -> closed t15..t20
        wait_ticks(2);
        pulse();                        // fourth sample at t20 = open entry
        wait_ticks(1);
        chk("R7 late-start trigger accepted", rst_out_n, 1'b1);
        wait_ticks(7);
        pulse();                        // t32 inside open t27..t34
        chk("R6 trigger inside open window", rst_out_n, 1'b1);
        wait_ticks(13);
        chk("R5 R6 open window before timeout t45", rst_out_n, 1'b1);
        wait_ticks(1);
        chk("R6 open window timeout t46", rst_out_n, 1'b0);
        wait_ticks(3);
        chk("R8 back to ignore", rst_out_n, 1'b1);

        // pretrigger in closed window
        wait_ticks(10);
        pulse();                        // t14 -> closed
        pulse();                        // t18 inside closed
        wait_ticks(1);
        chk("R5 pretrigger gives reset", rst_out_n, 1'b0);
        wait_ticks(2);
        chk("R8 pretrigger reset length", rst_out_n, 1'b1);

        // filter pattern table
        for (int v = 0; v < 8; v++) begin
            restart();
            wait_ticks(9);
            pulse();                    // closed t15..t20
            for (int b = 5; b >= 0; b--) begin
                trig_in = VEC_TAB[v][b+1];
                wait_ticks(1);
            end
            trig_in = 1'b0;
            chk($sformatf("R2 pattern %06b", VEC_TAB[v][6:1]), rst_out_n, !VEC_TAB[v][0]);
        end

        // enable hysteresis
        restart();
        wait_ticks(9);
        cur_lo = 1'b1;
        wait_ticks(1);
        cur_lo = 1'b0;                  // both flags low: stay disabled
        wait_ticks(41);
        chk("R9 disabled holds with both flags low", rst_out_n, 1'b1);
        cur_hi = 1'b1;
        cur_lo = 1'b1;                  // both high: enable wins
        wait_ticks(1);
        cur_hi = 1'b0;
        cur_lo = 1'b0;
        wait_ticks(38);
        chk("R9 re-enable restarts ignore+long t39", rst_out_n, 1'b1);
        wait_ticks(1);
        chk("R9 re-enable long window timeout t40", rst_out_n, 1'b0);
        wait_ticks(3);
        chk("R8 reset ends after re-enable", rst_out_n, 1'b1);

        // mode off and mode ignored outside ignore window
        mode = 2'b10;
        wait_ticks(45);
        chk("R10 mode off keeps reset released", rst_out_n, 1'b1);
        mode = 2'b00;
        wait_ticks(10);
        mode = 2'b10;                   // in long open: no effect
        wait_ticks(29);
        chk("R10 mode change in open ignored t39", rst_out_n, 1'b1);
        wait_ticks(1);
        chk("R10 mode change in open ignored t40", rst_out_n, 1'b0);
        mode = 2'b00;
        wait_ticks(3);
        chk("R10 fast ignore after reset", rst_out_n, 1'b1);

        // slow timing
        mode = 2'b01;
        wait_ticks(79);
        chk("R10 slow long open before timeout t79", rst_out_n, 1'b1);
        wait_ticks(1);
        chk("R10 slow long open timeout t80", rst_out_n, 1'b0);
        wait_ticks(5);
        chk("R10 slow reset pulse still low", rst_out_n, 1'b0);
        wait_ticks(1);
        chk("R10 slow reset pulse ends", rst_out_n, 1'b1);
        wait_ticks(20);
        pulse();                        // t24 -> slow closed t25..t36
        wait_ticks(2);
        pulse();                        // t30 inside slow closed
        wait_ticks(1);
        chk("R10 slow closed window pretrigger", rst_out_n, 1'b0);
        mode = 2'b00;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule